// File: doc/BRIEF.md
# Compare-Match Tick Timer

This block is a 32-bit up-counter that advances on a slow, fixed-rate tick taken from a prescaler on the system clock. A compare register sets the point at which a match event fires. On a match the timer can return to zero for periodic operation. It also adds one to a small saturating match tally, so software that services the timer late can still learn how many periods went by. Each match also raises an interrupt request. That request is gated by an enable bit and carries a programmable priority level.

Software reaches the block over a simple synchronous bus with a two-bit word address. Address 0 is the live counter and address 1 is the compare value. Address 2 is the control byte and address 3 is the interrupt-control byte. The counter always reads back its live value, and the match tally is never captured together with it. Software therefore reads the counter twice and looks for a wrap to decide which tally value goes with which count.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, all four registers read zero and both `irq_out` and `irq_level` are zero.
- R2: While control bit 0 (run) is set, the counter goes up by one every `PRESCALE_DIV` clocks. The prescaler starts from phase zero each time run is set, so the first increment takes effect on the `PRESCALE_DIV`-th clock edge after the edge that wrote run.
- R3: While run is clear, the counter keeps its value.
- R4: A write to address 0 loads the counter. The counter wraps from all-ones to zero. A read of address 0 returns the live count. Read data is registered and appears one clock after the address is presented.
- R5: A match event occurs when a tick brings the counter to the value in the compare register (address 1). A direct write of the counter never produces a match. When control bit 1 is clear, the counter carries on past the compare value.
- R6: When control bit 1 (restart-on-match) is set, the counter goes to zero on the tick after it reached the compare value, so its value never exceeds the compare value.
- R7: Control bits 7:4 count match events and hold at 15 instead of wrapping. Data written to bits 7:4 is ignored.
- R8: Writing control with bit 2 set zeroes the match tally. Control bits 2 and 3 always read as zero.
- R9: A match sets interrupt-control bit 5 (pending). `irq_out` goes high one clock after pending and enable (interrupt-control bit 4) are both set. While `irq_out` is high, `irq_level` shows bits 2:0 of interrupt control; otherwise `irq_level` is zero.
- R10: Writing interrupt control with bit 3 set drops pending, and bit 3 reads as zero. Writing zero disables the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word address: 0 counter, 1 compare, 2 control, 3 interrupt control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_out | output | 1 | Interrupt request, high while pending and enabled |
| irq_level | output | 3 | Priority level of the active request, zero when idle |

## Verification
The bench builds the timer with `PRESCALE_DIV` set to 4, so one tick spans four clocks. With that setting, tick-exact sampling of the counter and of the interrupt edge costs only a few dozen cycles. A short compare period of three ticks lets the match tally reach its saturation limit within a couple of hundred clocks. The counter keeps its full 32-bit width, and the wrap from all-ones to zero is reached by loading a value just below all-ones before starting the count.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    A_COUNT   = 2'd0,
    A_COMPARE = 2'd1,
    A_CTRL    = 2'd2,
    A_ICTRL   = 2'd3
  } reg_addr_e;

  // control byte fields
  localparam int CTL_RUN    = 0;
  localparam int CTL_RESTART = 1;
  localparam int CTL_CLRTAL = 2;
  localparam int CTL_TAL_LO = 4;

  // interrupt-control byte fields
  localparam int IC_CLR  = 3;
  localparam int IC_EN   = 4;
  localparam int IC_PEND = 5;
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run)        phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + PW'(1);
  end

  assign tick = run && (phase == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && tick) |=> !tick) else $error("tick repeated"); // R2
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CW = 32,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] cmp,
  input  logic          clr_tally,
  output logic [CW-1:0] cnt,
  output logic [OW-1:0] tally,
  output logic          hit
);
  logic [CW-1:0] nxt;

  always_comb begin
    if (restart && cnt == cmp) nxt = '0;
    else                       nxt = cnt + CW'(1);
  end

  // a match is only produced by a tick, never by a direct load
  assign hit = tick && !load && (nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                      tally <= '0;
    else if (clr_tally)           tally <= hit ? OW'(1) : '0;
    else if (hit && tally != '1)  tally <= tally + OW'(1);
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt)) else $error("count moved"); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && restart && cnt == cmp) |=> cnt == '0) else $error("no restart"); // R6
  AST_TALLY_SAT: assert property (@(posedge clk) disable iff (rst)
    (tally == '1 && !clr_tally) |=> tally == '1) else $error("tally wrapped"); // R7
  AST_TALLY_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_tally && !hit) |=> tally == '0) else $error("tally not cleared"); // R8
endmodule

// File: rtl/tct_irq.sv
module tct_irq #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [7:0]    wbyte,
  input  logic          hit,
  output logic [LW-1:0] lvl,
  output logic          ien,
  output logic          pend,
  output logic          irq_out,
  output logic [LW-1:0] irq_level
);
  import tct_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl       <= '0;
      ien       <= 1'b0;
      pend      <= 1'b0;
      irq_out   <= 1'b0;
      irq_level <= '0;
    end else begin
      if (wr) begin
        lvl <= wbyte[LW-1:0];
        ien <= wbyte[IC_EN];
      end
      if (hit)                       pend <= 1'b1;
      else if (wr && wbyte[IC_CLR])  pend <= 1'b0;
      irq_out   <= pend && ien;
      irq_level <= (pend && ien) ? lvl : '0;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend) else $error("pending missed"); // R9
  AST_LVL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> irq_level == '0) else $error("level while idle"); // R9
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr && wbyte[IC_CLR] && !hit) |=> !pend) else $error("pending kept"); // R10
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int PRESCALE_DIV = 100,
  parameter int CW           = 32,
  parameter int OW           = 4,
  parameter int LW           = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq_out,
  output logic [LW-1:0] irq_level
);
  import tct_pkg::*;

  logic [CW-1:0] cmp_q, cnt;
  logic          run_q, restart_q;
  logic [OW-1:0] tally;
  logic          tick, hit, ien, pend;
  logic [LW-1:0] lvl;
  logic          wr_cnt, wr_cmp, wr_ctl, wr_ic;

  assign wr_cnt = bus_wr && (bus_addr == A_COUNT);
  assign wr_cmp = bus_wr && (bus_addr == A_COMPARE);
  assign wr_ctl = bus_wr && (bus_addr == A_CTRL);
  assign wr_ic  = bus_wr && (bus_addr == A_ICTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q     <= '0;
      run_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= bus_wdata;
      if (wr_ctl) begin
        run_q     <= bus_wdata[CTL_RUN];
        restart_q <= bus_wdata[CTL_RESTART];
      end
    end
  end

  tct_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick)
  );

  tct_counter #(.CW(CW), .OW(OW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart_q),
    .load(wr_cnt), .load_val(bus_wdata), .cmp(cmp_q),
    .clr_tally(wr_ctl && bus_wdata[CTL_CLRTAL]),
    .cnt(cnt), .tally(tally), .hit(hit)
  );

  tct_irq #(.LW(LW)) u_irq (
    .clk(clk), .rst(rst), .wr(wr_ic), .wbyte(bus_wdata[7:0]), .hit(hit),
    .lvl(lvl), .ien(ien), .pend(pend), .irq_out(irq_out), .irq_level(irq_level)
  );

  logic [CW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_COUNT:   rd_mux = cnt;
      A_COMPARE: rd_mux = cmp_q;
      A_CTRL: begin
        rd_mux[CTL_RUN]               = run_q;
        rd_mux[CTL_RESTART]           = restart_q;
        rd_mux[CTL_TAL_LO +: OW]      = tally;
      end
      default: begin
        rd_mux[LW-1:0]  = lvl;
        rd_mux[IC_EN]   = ien;
        rd_mux[IC_PEND] = pend;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(pend)) else $error("irq without pending"); // R9
endmodule

// File: tb/tick_cmp_timer_tb.sv
module tick_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [2:0]  irq_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_cmp_timer #(.PRESCALE_DIV(4)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .irq_level(irq_level)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
    check("R1 irq_level after reset", {29'b0, irq_level}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_0000);
    repeat (20) @(posedge clk);
    rd(2'd0, v);
    check("R3 counter held while run clear", v, 32'h0);
    wr(2'd2, 32'h1);
    repeat (40) @(posedge clk);
    rd(2'd0, v);
    check("R2 ten ticks after forty clocks", v, 32'd10);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd2);
    wr(2'd2, 32'h7);
    repeat (50) @(posedge clk);
    rd(2'd2, v);
    check("R7 tally after four periods", v, 32'h43);
    for (int i = 0; i < 20; i++) begin
      rd(2'd0, v);
      check("R6 counter never above compare", {31'b0, v <= 32'd2}, 32'h1);
    end
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    repeat (200) @(posedge clk);
    rd(2'd2, v);
    check("R7 tally saturates at 15", v, 32'hF3);
    wr(2'd2, 32'h2);
    rd(2'd2, v);
    check("R7 tally kept when stopped", v, 32'hF2);
    wr(2'd2, 32'h6);
    rd(2'd2, v);
    check("R8 clear zeroes tally, bit 2 reads 0", v, 32'h02);
    wr(2'd2, 32'hF2);
    rd(2'd2, v);
    check("R7 written tally bits ignored", v, 32'h02);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    rd(2'd3, v);
    check("R9 pending set by match", v, 32'h20);
    check("R9 no irq while disabled", {31'b0, irq_out}, 32'h0);
    wr(2'd3, 32'h15);
    rd(2'd3, v);
    check("R9 enable and level read back", v, 32'h35);
    check("R9 irq asserted", {31'b0, irq_out}, 32'h1);
    check("R9 irq carries level", {29'b0, irq_level}, 32'd5);
    wr(2'd3, 32'h1D);
    rd(2'd3, v);
    check("R10 clear drops pending, bit 3 reads 0", v, 32'h15);
    check("R10 irq drops after clear", {31'b0, irq_out}, 32'h0);
    check("R9 level zero when idle", {29'b0, irq_level}, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd3, v);
    check("R10 write zero disables", v, 32'h0);
  endtask

  task automatic t_free_run();
    logic [31:0] v;
    wr(2'd0, 32'h0E);
    wr(2'd1, 32'h10);
    wr(2'd3, 32'h13);
    wr(2'd2, 32'h1);
    repeat (8) @(posedge clk);
    rd(2'd0, v);
    check("R5 counter reaches compare", v, 32'h10);
    check("R9 irq one clock after match", {31'b0, irq_out}, 32'h1);
    check("R9 irq level 3", {29'b0, irq_level}, 32'd3);
    repeat (20) @(posedge clk);
    rd(2'd0, v);
    check("R5 counter continues past compare", v, 32'h15);
    rd(2'd2, v);
    check("R5 one match counted", v, 32'h11);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h08);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'd5);
    rd(2'd0, v);
    check("R4 counter load reads back", v, 32'hFFFF_FFFE);
    rd(2'd3, v);
    check("R5 load never matches", v, 32'h0);
    wr(2'd2, 32'h1);
    repeat (8) @(posedge clk);
    rd(2'd0, v);
    check("R4 wrap to zero", v, 32'h0);
    wr(2'd2, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_enable();
    t_periodic();
    t_saturate();
    t_irq();
    t_free_run();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule